// File: doc/BRIEF.md
# Parallel Flash Command Decoder

This block models the command side of a parallel NOR-style flash device and sits in front of a small internal word array. On each clock it samples chip-select, write-enable and output-enable, all active low, along with a word address and a 16-bit data bus. A bus write is taken once, at the first clock on which the write strobes are asserted. A read drives data for as long as its strobes stay asserted.

Multi-write unlock sequences move the decoder between its modes:
- array read;
- identification (autoselect);
- a fast-program bypass mode;
- program;
- sector erase;
- chip erase.

Program and erase last a parameterised number of clocks. During that time reads return a status byte instead of array data. A byte/word select input switches the bus to 8-bit operation. In that mode data line 15 becomes the lowest address bit.

The decoder's states are:
- `ST_READ`: the idle array read mode.
- `ST_UNL1` and `ST_UNL2`: first and second unlock key seen.
- `ST_PGM_DATA`: waiting for the program data write.
- `ST_ERS_SETUP`, `ST_ERS_UNL1` and `ST_ERS_UNL2`: the second unlock pair of an erase.
- `ST_SECT_WIN`: the window in which more sector addresses can be added.
- `ST_AUTOSEL`: identification mode.
- `ST_BYP`: bypass mode.
- `ST_BYP_PGM`: bypass data write pending.
- `ST_BYP_EXIT`: bypass exit pending.
- `ST_BUSY_PGM` and `ST_BUSY_ERS`: the timed operations.

The transitions are:
- `ST_READ` goes to `ST_UNL1` on key AA at word address 0x15.
- `ST_UNL1` goes to `ST_UNL2` on key 55 at 0x2A.
- `ST_UNL2` dispatches on a command at 0x15: A0 to `ST_PGM_DATA`, 90 to `ST_AUTOSEL`, 80 to `ST_ERS_SETUP`, 20 to `ST_BYP`.
- `ST_ERS_SETUP` and `ST_ERS_UNL1` repeat the two keys.
- `ST_ERS_UNL2` goes to `ST_BUSY_ERS` on 10 at 0x15, or to `ST_SECT_WIN` on 30 at any address.
- `ST_SECT_WIN` goes to `ST_BUSY_ERS` when its window expires.
- `ST_AUTOSEL` goes to `ST_READ` on F0.
- `ST_BYP` goes to `ST_BYP_PGM` on A0, or to `ST_BYP_EXIT` on 90.
- `ST_BYP_EXIT` goes to `ST_READ` on 00, and otherwise back to `ST_BYP`.
- `ST_PGM_DATA` and `ST_BYP_PGM` go to `ST_BUSY_PGM` on any write.
- `ST_BUSY_PGM` returns to `ST_READ` or `ST_BYP` when its count ends.
- `ST_BUSY_ERS` returns to `ST_READ` when its count ends.
- Any write that does not fit an unlock step returns the decoder to `ST_READ`.

Top module: `flash_cmd_top`

## Requirements
- R1: While rst_n is low both output enables are low. After reset the decoder is in array read mode, so reads return array words with no command. A reset also drops bypass mode.
- R2: A write is accepted only when cs_n=0, we_n=0 and oe_n=1. A strobe with oe_n=0 has no effect.
- R3: dq_oe_lo is high only when rst_n=1, cs_n=0, oe_n=0 and we_n=1. dq_oe_hi also requires byte_n=1.
- R4: The unlock sequence is data AA at word address 0x15, then data 55 at 0x2A, then the command at 0x15 (data on dq_in[7:0]). A write that breaks the sequence returns the decoder to array read mode, and the broken sequence changes nothing.
- R5: Program is the unlock sequence, command A0, then one data write. The addressed word becomes old AND new, so bits only clear. It is stored PGM_CYC clocks after the data write.
- R6: While busy, reads return a status word on the low byte with the upper byte 0. Bit 7 is the complement of data bit 7 during program and 0 during erase. Bit 6 starts at 0 and inverts after each read. All other bits are 0.
- R7: With byte_n=0 the byte address is {addr, dq_in[15]}, and dq_in[15]=1 selects the high byte. Program data is dq_in[7:0]. Reads drive only the low byte.
- R8: Unlock then command 90 enters identification mode. There a read at addr[1:0]=0 returns MFR_CODE, 1 returns DEV_CODE, and any other value returns 0. A write of F0 returns to array read mode.
- R9: Unlock then command 20 enters bypass mode. In bypass, A0 followed by a data write programs, which is two writes. Writing 90 then 00 leaves bypass.
- R10: Erase is unlock, 80, unlock, then 30 at an address in the target sector, where the sector is given by the top address bits. Each further 30 written within WIN_CYC clocks adds a sector. When the window expires the selected sectors are set to all ones.
- R11: Erase is unlock, 80, unlock, then 10 at 0x15. This sets every word to FFFF.
- R12: Writes that arrive while an operation is busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| byte_n | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| addr | input | AW | Word address |
| dq_in | input | 16 | Data in; bit 15 is the low address bit in 8-bit mode |
| dq_out | output | 16 | Read data |
| dq_oe_lo | output | 1 | Drive enable for dq_out[7:0] |
| dq_oe_hi | output | 1 | Drive enable for dq_out[15:8] |

## Verification
A wrong decoder state is seen on the very next read, and in one of three ways:
- the read returns a status word where array data is expected;
- the read returns an identification code;
- a later program or erase leaves the array unchanged.

A broken unlock step is caught by programming after it and reading the target word back. The toggle and polling bits are checked on back-to-back reads inside the busy period. Erase sector selection is checked by reading words in both erased and untouched sectors after the window expires.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
    typedef enum logic [3:0] {
        ST_READ, ST_UNL1, ST_UNL2, ST_PGM_DATA,
        ST_ERS_SETUP, ST_ERS_UNL1, ST_ERS_UNL2, ST_SECT_WIN,
        ST_AUTOSEL, ST_BYP, ST_BYP_PGM, ST_BYP_EXIT,
        ST_BUSY_PGM, ST_BUSY_ERS
    } fc_state_e;

    localparam logic [7:0] KEY_A       = 8'hAA;
    localparam logic [7:0] KEY_B       = 8'h55;
    localparam logic [7:0] CMD_PGM     = 8'hA0;
    localparam logic [7:0] CMD_ASEL    = 8'h90;
    localparam logic [7:0] CMD_ERS     = 8'h80;
    localparam logic [7:0] CMD_BYP     = 8'h20;
    localparam logic [7:0] CMD_CHIP    = 8'h10;
    localparam logic [7:0] CMD_SECT    = 8'h30;
    localparam logic [7:0] CMD_EXIT    = 8'hF0;
    localparam logic [7:0] CMD_BYP_END = 8'h00;
endpackage

// File: rtl/flash_bus_decode.sv
module flash_bus_decode (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic we_n,
    input  logic oe_n,
    output logic wr_pulse,
    output logic rd_pulse,
    output logic rd_en
);
    logic wr_act, rd_act, wr_q, rd_q;

    // R2: write cycle qualifier; R3: read drive qualifier
    assign wr_act = rst_n & ~cs_n & ~we_n & oe_n;
    assign rd_act = rst_n & ~cs_n & ~oe_n & we_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q <= 1'b0;
            rd_q <= 1'b0;
        end else begin
            wr_q <= wr_act;
            rd_q <= rd_act;
        end
    end

    assign wr_pulse = wr_act & ~wr_q;
    assign rd_pulse = rd_act & ~rd_q;
    assign rd_en    = rd_act;
endmodule

// File: rtl/flash_array.sv
module flash_array #(
    parameter int AW    = 6,
    parameter int SECTS = 4
) (
    input  logic             clk,
    input  logic             pgm_go,
    input  logic [AW-1:0]    pgm_addr,
    input  logic [1:0]       pgm_be,
    input  logic [15:0]      pgm_data,
    input  logic             ers_go,
    input  logic [SECTS-1:0] ers_mask,
    input  logic [AW-1:0]    rd_addr,
    output logic [15:0]      rd_data
);
    localparam int WORDS  = 1 << AW;
    localparam int SECT_W = WORDS / SECTS;

    logic [15:0]      mem [WORDS];
    logic [WORDS-1:0] ers_hit;

    // per-word erase strobe from the sector mask
    for (genvar w = 0; w < WORDS; w++) begin : g_hit
        assign ers_hit[w] = ers_go & ers_mask[w / SECT_W];
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < WORDS; i++) begin
            if (ers_hit[i]) mem[i] <= 16'hFFFF;
        end
        if (pgm_go) begin
            // R5: programming can only clear bits
            for (int b = 0; b < 2; b++) begin
                if (pgm_be[b]) mem[pgm_addr][b*8 +: 8] <= mem[pgm_addr][b*8 +: 8] & pgm_data[b*8 +: 8];
            end
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
    import flash_cmd_pkg::*;
#(
    parameter int            AW      = 6,
    parameter int            SECTS   = 4,
    parameter int            PGM_CYC = 8,
    parameter int            ERS_CYC = 20,
    parameter int            WIN_CYC = 6,
    parameter logic [AW-1:0] UNL_A1  = 'h15,
    parameter logic [AW-1:0] UNL_A2  = 'h2A
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_pulse,
    input  logic             rd_pulse,
    input  logic [AW-1:0]    addr,
    input  logic [15:0]      dq_in,
    input  logic             byte_mode,
    output fc_state_e        state,
    output logic             status_mode,
    output logic             pgm_status,
    output logic             poll_bit,
    output logic             tog,
    output logic             pgm_go,
    output logic [AW-1:0]    pgm_addr,
    output logic [1:0]       pgm_be,
    output logic [15:0]      pgm_data,
    output logic             ers_go,
    output logic [SECTS-1:0] ers_mask
);
    localparam int SB   = $clog2(SECTS);
    localparam int MAXC = (PGM_CYC > ERS_CYC) ? ((PGM_CYC > WIN_CYC) ? PGM_CYC : WIN_CYC)
                                              : ((ERS_CYC > WIN_CYC) ? ERS_CYC : WIN_CYC);
    localparam int CW   = $clog2(MAXC + 1);

    fc_state_e        st_q, st_d;
    logic [CW-1:0]    cnt_q, cnt_d;
    logic [SECTS-1:0] mask_q, mask_d, sect_hot;
    logic             byp_q, byp_d, poll_q, poll_d, tog_q, tog_d;
    logic [AW-1:0]    pa_q, pa_d;
    logic [1:0]       pbe_q, pbe_d;
    logic [15:0]      pd_q, pd_d;
    logic [7:0]       dbyte;
    logic             at_a1, at_a2, busy_q, busy_d;

    assign dbyte = dq_in[7:0];
    assign at_a1 = (addr == UNL_A1);
    assign at_a2 = (addr == UNL_A2);

    always_comb begin
        sect_hot = '0;
        sect_hot[addr[AW-1 -: SB]] = 1'b1;
    end

    // next-state and operation latching
    always_comb begin
        st_d   = st_q;
        cnt_d  = (cnt_q != '0) ? cnt_q - 1'b1 : cnt_q;
        mask_d = mask_q;
        byp_d  = byp_q;
        pa_d   = pa_q;
        pbe_d  = pbe_q;
        pd_d   = pd_q;
        poll_d = poll_q;
        pgm_go = 1'b0;
        ers_go = 1'b0;
        unique case (st_q)
            ST_READ: begin
                if (wr_pulse && at_a1 && dbyte == KEY_A) st_d = ST_UNL1;
            end
            ST_UNL1: begin
                if (wr_pulse) st_d = (at_a2 && dbyte == KEY_B) ? ST_UNL2 : ST_READ;
            end
            ST_UNL2: begin
                if (wr_pulse) begin
                    st_d = ST_READ;
                    if (at_a1) begin
                        if (dbyte == CMD_PGM)  st_d = ST_PGM_DATA;
                        if (dbyte == CMD_ASEL) st_d = ST_AUTOSEL;
                        if (dbyte == CMD_ERS)  st_d = ST_ERS_SETUP;
                        if (dbyte == CMD_BYP)  st_d = ST_BYP;
                    end
                end
            end
            ST_PGM_DATA, ST_BYP_PGM: begin
                if (wr_pulse) begin
                    st_d   = ST_BUSY_PGM;
                    cnt_d  = CW'(PGM_CYC - 1);
                    byp_d  = (st_q == ST_BYP_PGM);
                    pa_d   = addr;
                    pbe_d  = byte_mode ? (dq_in[15] ? 2'b10 : 2'b01) : 2'b11;
                    pd_d   = byte_mode ? {dbyte, dbyte} : dq_in;
                    poll_d = dq_in[7];
                end
            end
            ST_ERS_SETUP: begin
                if (wr_pulse) st_d = (at_a1 && dbyte == KEY_A) ? ST_ERS_UNL1 : ST_READ;
            end
            ST_ERS_UNL1: begin
                if (wr_pulse) st_d = (at_a2 && dbyte == KEY_B) ? ST_ERS_UNL2 : ST_READ;
            end
            ST_ERS_UNL2: begin
                if (wr_pulse) begin
                    st_d = ST_READ;
                    if (at_a1 && dbyte == CMD_CHIP) begin
                        st_d   = ST_BUSY_ERS;
                        mask_d = '1;
                        cnt_d  = CW'(ERS_CYC - 1);
                    end else if (dbyte == CMD_SECT) begin
                        st_d   = ST_SECT_WIN;
                        mask_d = sect_hot;
                        cnt_d  = CW'(WIN_CYC - 1);
                    end
                end
            end
            ST_SECT_WIN: begin
                if (wr_pulse) begin
                    if (dbyte == CMD_SECT) begin
                        mask_d = mask_q | sect_hot;
                        cnt_d  = CW'(WIN_CYC - 1);
                    end else begin
                        st_d   = ST_READ;
                        mask_d = '0;
                    end
                end else if (cnt_q == '0) begin
                    st_d  = ST_BUSY_ERS;
                    cnt_d = CW'(ERS_CYC - 1);
                end
            end
            ST_AUTOSEL: begin
                if (wr_pulse && dbyte == CMD_EXIT) st_d = ST_READ;
            end
            ST_BYP: begin
                if (wr_pulse && dbyte == CMD_PGM)  st_d = ST_BYP_PGM;
                if (wr_pulse && dbyte == CMD_ASEL) st_d = ST_BYP_EXIT;
            end
            ST_BYP_EXIT: begin
                if (wr_pulse) st_d = (dbyte == CMD_BYP_END) ? ST_READ : ST_BYP;
            end
            ST_BUSY_PGM: begin
                if (cnt_q == '0) begin
                    pgm_go = 1'b1;
                    st_d   = byp_q ? ST_BYP : ST_READ;
                end
            end
            ST_BUSY_ERS: begin
                if (cnt_q == '0) begin
                    ers_go = 1'b1;
                    st_d   = ST_READ;
                end
            end
            default: st_d = ST_READ;
        endcase
    end

    assign busy_q = (st_q == ST_BUSY_PGM) || (st_q == ST_BUSY_ERS) || (st_q == ST_SECT_WIN);
    assign busy_d = (st_d == ST_BUSY_PGM) || (st_d == ST_BUSY_ERS) || (st_d == ST_SECT_WIN);

    // R6: toggle bit cleared at operation start, flipped by each status read
    always_comb begin
        tog_d = tog_q;
        if (busy_q && rd_pulse) tog_d = ~tog_q;
        if (!busy_q && busy_d)  tog_d = 1'b0;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_READ;
            cnt_q  <= '0;
            mask_q <= '0;
            byp_q  <= 1'b0;
            pa_q   <= '0;
            pbe_q  <= '0;
            pd_q   <= '0;
            poll_q <= 1'b0;
            tog_q  <= 1'b0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            mask_q <= mask_d;
            byp_q  <= byp_d;
            pa_q   <= pa_d;
            pbe_q  <= pbe_d;
            pd_q   <= pd_d;
            poll_q <= poll_d;
            tog_q  <= tog_d;
        end
    end

    assign state       = st_q;
    assign status_mode = busy_q;
    assign pgm_status  = (st_q == ST_BUSY_PGM);
    assign poll_bit    = poll_q;
    assign tog         = tog_q;
    assign pgm_addr    = pa_q;
    assign pgm_be      = pbe_q;
    assign pgm_data    = pd_q;
    assign ers_mask    = mask_q;
endmodule

// File: rtl/flash_cmd_top.sv
module flash_cmd_top
    import flash_cmd_pkg::*;
#(
    parameter int            AW       = 6,
    parameter int            SECTS    = 4,
    parameter int            PGM_CYC  = 8,
    parameter int            ERS_CYC  = 20,
    parameter int            WIN_CYC  = 6,
    parameter logic [AW-1:0] UNL_A1   = 'h15,
    parameter logic [AW-1:0] UNL_A2   = 'h2A,
    parameter logic [7:0]    MFR_CODE = 8'h5A,
    parameter logic [7:0]    DEV_CODE = 8'hC3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic          byte_n,
    input  logic [AW-1:0] addr,
    input  logic [15:0]   dq_in,
    output logic [15:0]   dq_out,
    output logic          dq_oe_lo,
    output logic          dq_oe_hi
);
    logic             wr_pulse, rd_pulse, rd_en;
    fc_state_e        state;
    logic             status_mode, pgm_status, poll_bit, tog;
    logic             pgm_go, ers_go;
    logic [AW-1:0]    pgm_addr;
    logic [1:0]       pgm_be;
    logic [15:0]      pgm_data, arr_word, sel_word;
    logic [SECTS-1:0] ers_mask;
    logic [7:0]       id_code;
    logic             byte_mode;

    assign byte_mode = ~byte_n;

    flash_bus_decode u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .we_n     (we_n),
        .oe_n     (oe_n),
        .wr_pulse (wr_pulse),
        .rd_pulse (rd_pulse),
        .rd_en    (rd_en)
    );

    flash_cmd_fsm #(
        .AW(AW), .SECTS(SECTS), .PGM_CYC(PGM_CYC), .ERS_CYC(ERS_CYC),
        .WIN_CYC(WIN_CYC), .UNL_A1(UNL_A1), .UNL_A2(UNL_A2)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_pulse    (wr_pulse),
        .rd_pulse    (rd_pulse),
        .addr        (addr),
        .dq_in       (dq_in),
        .byte_mode   (byte_mode),
        .state       (state),
        .status_mode (status_mode),
        .pgm_status  (pgm_status),
        .poll_bit    (poll_bit),
        .tog         (tog),
        .pgm_go      (pgm_go),
        .pgm_addr    (pgm_addr),
        .pgm_be      (pgm_be),
        .pgm_data    (pgm_data),
        .ers_go      (ers_go),
        .ers_mask    (ers_mask)
    );

    flash_array #(.AW(AW), .SECTS(SECTS)) u_arr (
        .clk      (clk),
        .pgm_go   (pgm_go),
        .pgm_addr (pgm_addr),
        .pgm_be   (pgm_be),
        .pgm_data (pgm_data),
        .ers_go   (ers_go),
        .ers_mask (ers_mask),
        .rd_addr  (addr),
        .rd_data  (arr_word)
    );

    // R8: identification codes
    always_comb begin
        unique case (addr[1:0])
            2'd0:    id_code = MFR_CODE;
            2'd1:    id_code = DEV_CODE;
            default: id_code = 8'h00;
        endcase
    end

    // output selection: status, identification or array data
    always_comb begin
        if (status_mode)
            sel_word = {8'h00, pgm_status & ~poll_bit, tog, 6'b0};
        else if (state == ST_AUTOSEL)
            sel_word = {8'h00, id_code};
        else
            sel_word = arr_word;
        if (byte_mode) begin
            if (!status_mode && state != ST_AUTOSEL && dq_in[15])
                dq_out = {8'h00, sel_word[15:8]};
            else
                dq_out = {8'h00, sel_word[7:0]};
        end else begin
            dq_out = sel_word;
        end
    end

    assign dq_oe_lo = rd_en;
    assign dq_oe_hi = rd_en & ~byte_mode;
endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk
    import flash_cmd_pkg::*;
#(
    parameter int AW    = 6,
    parameter int SECTS = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             oe_n,
    input logic             byte_n,
    input logic [15:0]      dq_out,
    input logic             dq_oe_lo,
    input logic             dq_oe_hi,
    input logic             status_mode,
    input fc_state_e        state,
    input logic [AW-1:0]    pgm_addr,
    input logic             ers_go,
    input logic [SECTS-1:0] ers_mask
);
    always_comb begin
        if (!rst_n) a_r1_reset_hiz: assert (!dq_oe_lo && !dq_oe_hi);
    end

    a_r3_hiz_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || oe_n) |-> (!dq_oe_lo && !dq_oe_hi));

    a_r7_byte_low_only: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_n |-> !dq_oe_hi);

    a_r6_status_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (status_mode && dq_oe_hi) |-> (dq_out[15:8] == 8'h00));

    a_r12_target_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY_PGM && $past(state) == ST_BUSY_PGM) |-> $stable(pgm_addr));

    a_r10_mask_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        ers_go |-> (ers_mask != '0));
endmodule

bind flash_cmd_top flash_cmd_chk #(.AW(AW), .SECTS(SECTS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .oe_n        (oe_n),
    .byte_n      (byte_n),
    .dq_out      (dq_out),
    .dq_oe_lo    (dq_oe_lo),
    .dq_oe_hi    (dq_oe_hi),
    .status_mode (status_mode),
    .state       (state),
    .pgm_addr    (pgm_addr),
    .ers_go      (ers_go),
    .ers_mask    (ers_mask)
);

// File: tb/flash_cmd_top_tb.sv
module flash_cmd_top_tb;
    localparam logic [1:0] OP_W = 2'd0, OP_R = 2'd1, OP_T = 2'd2;
    localparam int NV = 33;
    // {req, op, addr, data, expected}
    localparam logic [43:0] VEC [NV] = '{
        {4'd11, OP_W, 6'h15, 16'h00AA, 16'h0},   // R11 chip erase
        {4'd11, OP_W, 6'h2A, 16'h0055, 16'h0},
        {4'd11, OP_W, 6'h15, 16'h0080, 16'h0},
        {4'd11, OP_W, 6'h15, 16'h00AA, 16'h0},
        {4'd11, OP_W, 6'h2A, 16'h0055, 16'h0},
        {4'd11, OP_W, 6'h15, 16'h0010, 16'h0},
        {4'd6,  OP_R, 6'h00, 16'h0,    16'h0000}, // R6 erase status
        {4'd6,  OP_R, 6'h00, 16'h0,    16'h0040}, // R6 toggle
        {4'd11, OP_T, 6'h00, 16'd25,   16'h0},
        {4'd11, OP_R, 6'h00, 16'h0,    16'hFFFF},
        {4'd11, OP_R, 6'h3F, 16'h0,    16'hFFFF},
        {4'd5,  OP_W, 6'h15, 16'h00AA, 16'h0},   // R5 program
        {4'd5,  OP_W, 6'h2A, 16'h0055, 16'h0},
        {4'd5,  OP_W, 6'h15, 16'h00A0, 16'h0},
        {4'd5,  OP_W, 6'h05, 16'h1234, 16'h0},
        {4'd6,  OP_R, 6'h05, 16'h0,    16'h0080}, // R6 polling bit
        {4'd6,  OP_R, 6'h05, 16'h0,    16'h00C0},
        {4'd5,  OP_T, 6'h00, 16'd10,   16'h0},
        {4'd5,  OP_R, 6'h05, 16'h0,    16'h1234},
        {4'd5,  OP_W, 6'h15, 16'h00AA, 16'h0},
        {4'd5,  OP_W, 6'h2A, 16'h0055, 16'h0},
        {4'd5,  OP_W, 6'h15, 16'h00A0, 16'h0},
        {4'd5,  OP_W, 6'h05, 16'hFF00, 16'h0},
        {4'd5,  OP_T, 6'h00, 16'd10,   16'h0},
        {4'd5,  OP_R, 6'h05, 16'h0,    16'h1200}, // R5 clear-only
        {4'd8,  OP_W, 6'h15, 16'h00AA, 16'h0},   // R8 identification
        {4'd8,  OP_W, 6'h2A, 16'h0055, 16'h0},
        {4'd8,  OP_W, 6'h15, 16'h0090, 16'h0},
        {4'd8,  OP_R, 6'h00, 16'h0,    16'h005A},
        {4'd8,  OP_R, 6'h01, 16'h0,    16'h00C3},
        {4'd8,  OP_R, 6'h02, 16'h0,    16'h0000},
        {4'd8,  OP_W, 6'h00, 16'h00F0, 16'h0},
        {4'd8,  OP_R, 6'h05, 16'h0,    16'h1200}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, byte_n = 1'b1;
    logic [5:0]  addr = '0;
    logic [15:0] dq_in = '0;
    logic [15:0] dq_out;
    logic        dq_oe_lo, dq_oe_hi;
    int          total = 0, bad = 0;
    logic        done = 1'b0;

    always #10 clk = ~clk;

    flash_cmd_top u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
        .byte_n(byte_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
        .dq_oe_lo(dq_oe_lo), .dq_oe_hi(dq_oe_hi)
    );

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic bus_wr(input logic [5:0] a, input logic [15:0] d, input logic oe_lvl = 1'b1);
        @(negedge clk);
        addr = a; dq_in = d; cs_n = 1'b0; we_n = 1'b0; oe_n = oe_lvl;
        @(negedge clk);
        cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic bus_rd(input logic [5:0] a, input logic hsel, output logic [15:0] v,
                          output logic olo, output logic ohi);
        @(negedge clk);
        addr = a; dq_in = {hsel, 15'h0}; cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        #2;
        v = dq_out; olo = dq_oe_lo; ohi = dq_oe_hi;
        @(negedge clk);
        cs_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic unlock(input logic [7:0] cmd);
        bus_wr(6'h15, 16'h00AA);
        bus_wr(6'h2A, 16'h0055);
        bus_wr(6'h15, {8'h00, cmd});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic olo, ohi;
        // R1: outputs off while reset held, even with read strobes active
        cs_n = 1'b0; oe_n = 1'b0;
        #25;
        check("R1 reset hi-z", {14'h0, dq_oe_hi, dq_oe_lo}, 16'h0);
        cs_n = 1'b1; oe_n = 1'b1;
        @(negedge clk); rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [3:0]  rq;
            logic [1:0]  op;
            logic [5:0]  a;
            logic [15:0] d, e;
            {rq, op, a, d, e} = VEC[i];
            if (op == OP_W) bus_wr(a, d);
            else if (op == OP_T) wait_cyc(int'(d));
            else begin
                bus_rd(a, 1'b0, v, olo, ohi);
                total++;
                if (v !== e) begin
                    bad++;
                    $display("FAIL R%0d table step %0d: got %h expected %h", rq, i, v, e);
                end
            end
        end

        // R2: strobe with oe_n low is not a write
        unlock(8'hA0);
        bus_wr(6'h06, 16'h0000, 1'b0);
        bus_rd(6'h06, 1'b0, v, olo, ohi);
        check("R2 oe-low write ignored", v, 16'hFFFF);
        bus_wr(6'h06, 16'hFFFF);
        wait_cyc(10);

        // R4: broken unlock sequence
        bus_wr(6'h15, 16'h00AA);
        bus_wr(6'h2A, 16'h0054);
        bus_wr(6'h15, 16'h00A0);
        bus_wr(6'h07, 16'h0000);
        wait_cyc(10);
        bus_rd(6'h07, 1'b0, v, olo, ohi);
        check("R4 broken sequence", v, 16'hFFFF);

        // R3: drive enables
        @(negedge clk); cs_n = 1'b1; oe_n = 1'b0; #2;
        check("R3 cs high", {14'h0, dq_oe_hi, dq_oe_lo}, 16'h0);
        @(negedge clk); cs_n = 1'b0; oe_n = 1'b1; #2;
        check("R3 oe high", {14'h0, dq_oe_hi, dq_oe_lo}, 16'h0);
        @(negedge clk); oe_n = 1'b0; #2;
        check("R3 read drives", {14'h0, dq_oe_hi, dq_oe_lo}, 16'h3);
        @(negedge clk); cs_n = 1'b1; oe_n = 1'b1;

        // R7: byte mode program and read
        byte_n = 1'b0;
        unlock(8'hA0);
        bus_wr(6'h08, 16'h800F);
        wait_cyc(10);
        bus_rd(6'h08, 1'b1, v, olo, ohi);
        check("R7 high byte", {v[7:0], 6'h0, ohi, olo}, 16'h0F01);
        bus_rd(6'h08, 1'b0, v, olo, ohi);
        check("R7 low byte", {8'h0, v[7:0]}, 16'h00FF);
        byte_n = 1'b1;
        bus_rd(6'h08, 1'b0, v, olo, ohi);
        check("R7 word view", v, 16'h0FFF);

        // R9: bypass program with two writes, then exit
        unlock(8'h20);
        bus_wr(6'h00, 16'h00A0);
        bus_wr(6'h09, 16'h00AA);
        wait_cyc(10);
        bus_rd(6'h09, 1'b0, v, olo, ohi);
        check("R9 bypass program", v, 16'h00AA);
        bus_wr(6'h00, 16'h00A0);
        bus_wr(6'h0A, 16'h5555);
        bus_rd(6'h0A, 1'b0, v, olo, ohi);
        check("R9 bypass status", v, 16'h0080);
        wait_cyc(10);
        bus_rd(6'h0A, 1'b0, v, olo, ohi);
        check("R9 bypass data", v, 16'h5555);
        bus_wr(6'h00, 16'h0090);
        bus_wr(6'h00, 16'h0000);
        bus_wr(6'h00, 16'h00A0);
        bus_wr(6'h0B, 16'h0000);
        wait_cyc(10);
        bus_rd(6'h0B, 1'b0, v, olo, ohi);
        check("R9 bypass exited", v, 16'hFFFF);

        // R10: multi-sector erase
        unlock(8'h20);
        bus_wr(6'h00, 16'h00A0); bus_wr(6'h12, 16'h0000); wait_cyc(10);
        bus_wr(6'h00, 16'h00A0); bus_wr(6'h22, 16'h0000); wait_cyc(10);
        bus_wr(6'h00, 16'h00A0); bus_wr(6'h32, 16'h0000); wait_cyc(10);
        bus_wr(6'h00, 16'h0090); bus_wr(6'h00, 16'h0000);
        unlock(8'h80);
        bus_wr(6'h15, 16'h00AA);
        bus_wr(6'h2A, 16'h0055);
        bus_wr(6'h10, 16'h0030);
        bus_wr(6'h30, 16'h0030);
        wait_cyc(40);
        bus_rd(6'h12, 1'b0, v, olo, ohi);
        check("R10 sector1 erased", v, 16'hFFFF);
        bus_rd(6'h32, 1'b0, v, olo, ohi);
        check("R10 sector3 erased", v, 16'hFFFF);
        bus_rd(6'h22, 1'b0, v, olo, ohi);
        check("R10 sector2 kept", v, 16'h0000);
        bus_rd(6'h05, 1'b0, v, olo, ohi);
        check("R10 sector0 kept", v, 16'h1200);

        // R12: write during busy ignored
        unlock(8'hA0);
        bus_wr(6'h23, 16'h00FF);
        bus_wr(6'h23, 16'h0000);
        wait_cyc(12);
        bus_rd(6'h23, 1'b0, v, olo, ohi);
        check("R12 busy write ignored", v, 16'h00FF);

        // R1: reset drops bypass and returns to array read
        unlock(8'h20);
        @(negedge clk); rst_n = 1'b0; cs_n = 1'b0; oe_n = 1'b0; #2;
        check("R1 reset mid-mode hi-z", {14'h0, dq_oe_hi, dq_oe_lo}, 16'h0);
        @(negedge clk); cs_n = 1'b1; oe_n = 1'b1; rst_n = 1'b1;
        bus_wr(6'h00, 16'h00A0);
        bus_wr(6'h0C, 16'h0000);
        wait_cyc(10);
        bus_rd(6'h0C, 1'b0, v, olo, ohi);
        check("R1 array read after reset", v, 16'hFFFF);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule